// File: doc/BRIEF.md
# Hard-Decision QPSK Symbol Demapper

This block turns complex baseband samples, given as signed fixed-point I and Q words with a valid strobe, into hard-decision QPSK symbols. Where the constellation sits is fixed when the block is built. A phase parameter places point zero at angle 2π·PHASE/PHASE_DIV, and the other three points follow at quarter-turn steps.

The block handles the phase in one of two ways. If the phase is an odd multiple of π/4, the points already lie in the centres of the quadrants. The decision then comes straight from the signs of I and Q, and a constant index shift accounts for which quadrant holds point zero. For any other phase, each sample is first multiplied by a fixed-point rotation constant. This brings the points to π/4 + m·π/2, and only then is the quadrant decided.

The symbol comes out either as a 2-bit integer or as two serial bits, most significant bit first. Its ordering can be plain binary or Gray.

Top module: `qpsk_hard_demapper`

## Requirements
- R1: With binary ordering (GRAY=0), a sample near angle θ + m·π/2 gives symbol index m (0..3), where θ = 2π·PHASE/PHASE_DIV.
- R2: With Gray ordering (GRAY=1), index m is emitted as the pair 0→00, 1→01, 2→11, 3→10, where the pair is written first-bit second-bit.
- R3: In integer mode (BIT_OUT=0), out_sym is a 2-bit unsigned value. out_sym[1] is the first bit of the pair and out_sym[0] the second.
- R4: In bit mode (BIT_OUT=1), out_sym is 1 bit wide. A symbol produces its first (most significant) bit, then its second bit, on two consecutive cycles, with out_valid high on both.
- R5: In bit mode, in_ready is low in the cycle after each accepted symbol and high otherwise. In integer mode, in_ready is always high. A sample presented while in_ready is low is not taken.
- R6: When the phase is an odd multiple of π/4, no multiply is used. The result appears one cycle after the sample is accepted: the integer, or the first bit in bit mode.
- R7: For any other phase, the sample is rotated by −(θ − π/4) using COEF_W-bit constants. The result appears two cycles after acceptance.
- R8: The quadrant rule is as follows. I≥0 and Q≥0 gives quadrant 0; I<0 and Q≥0 gives 1; I<0 and Q<0 gives 2; I≥0 and Q<0 gives 3. A zero component counts as non-negative. The index is the quadrant minus the offset's quadrant, modulo 4.
- R9: The rounded rotation result saturates to the input width and keeps its sign, so full-scale inputs still decide correctly.
- R10: While rst_n is low and after it, until a sample is accepted, out_valid is low. In bit mode, in_ready is high once reset is over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_i | input | IN_W | In-phase component, signed |
| in_q | input | IN_W | Quadrature component, signed |
| out_valid | output | 1 | out_sym carries a result |
| out_sym | output | 2 or 1 | Symbol integer, or one serial bit in bit mode |

## Verification
Three situations are hard to reach from the ports.

The first is the bit-mode stall. The bench holds in_valid high across a change of sample while in_ready is low. It then checks that the bit stream holds only the samples presented in the ready cycles.

The second is saturation in the rotation. Full-scale inputs of equal magnitude on both axes push one rotated component past the input range. The expected index comes from the input angle.

The third is the zero-component rule. This is driven with exact zeros on I, on Q and on both, into the instances with no multiply, where the signs reach the decision unaltered.

// File: rtl/qdm_pkg.sv
// Package for the hard-decision QPSK demapper.
// Holds the elaboration-time maths: angle wrap, series cosine and sine,
// rounding, offset classification, the quadrant rule and the symbol ordering.
// Assumes 0 <= phase < phase_div.
package qdm_pkg;

    localparam real PI = 3.14159265358979323846;

    // Wrap an angle into [-pi, pi] so that the series converges fast.
    function automatic real wrap_angle(input real x);
        real y;
        y = x;
        while (y > PI)  y = y - 2.0 * PI;
        while (y < -PI) y = y + 2.0 * PI;
        return y;
    endfunction

    // Cosine by power series, used only for constants.
    function automatic real series_cos(input real x);
        real y, term, acc;
        y = wrap_angle(x);
        term = 1.0;
        acc = 1.0;
        for (int n = 1; n < 18; n++) begin
            term = -term * y * y / (real'(2 * n - 1) * real'(2 * n));
            acc = acc + term;
        end
        return acc;
    endfunction

    // Sine by power series, used only for constants.
    function automatic real series_sin(input real x);
        real y, term, acc;
        y = wrap_angle(x);
        term = y;
        acc = y;
        for (int n = 1; n < 18; n++) begin
            term = -term * y * y / (real'(2 * n) * real'(2 * n + 1));
            acc = acc + term;
        end
        return acc;
    endfunction

    // Round to the nearest integer, with halves going away from zero.
    function automatic int round_near(input real x);
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    // True when the phase is an odd multiple of pi/4.
    function automatic bit odd_eighth(input int ph, input int div);
        if (div % 8 != 0) return 1'b0;
        if (ph % (div / 8) != 0) return 1'b0;
        return ((ph / (div / 8)) % 2) == 1;
    endfunction

    // The quadrant that holds point zero when the phase needs no multiply.
    function automatic logic [1:0] offset_quadrant(input int ph, input int div);
        if (!odd_eighth(ph, div)) return 2'd0;
        return 2'(((ph / (div / 8)) - 1) / 2);
    endfunction

    // The rotation angle that brings point zero to pi/4.
    function automatic real derot_angle(input int ph, input int div);
        return 2.0 * PI * real'(ph) / real'(div) - PI / 4.0;
    endfunction

    // Quadrant from the sign bits; a zero component counts as non-negative.
    function automatic logic [1:0] quadrant(input logic neg_i, input logic neg_q);
        case ({neg_i, neg_q})
            2'b00:   return 2'd0;
            2'b10:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Index to output pair, in binary or Gray ordering.
    function automatic logic [1:0] order_sym(input logic [1:0] idx, input bit gray);
        return gray ? {idx[1], idx[1] ^ idx[0]} : idx;
    endfunction

endpackage

// File: rtl/qdm_derotator.sv
// Fixed-point derotator.
// Multiplies (I + jQ) by cos(a) - j sin(a), with the constants held in COEF_W
// bits and COEF_W-2 fraction bits. It rounds the result back to the input
// scale and saturates to IN_W bits, so the sign is never lost. The result is
// registered, which gives one cycle of latency.
// Assumes COEF_W >= 3.
module qdm_derotator #(
    parameter int IN_W   = 12,
    parameter int COEF_W = 12,
    parameter logic signed [COEF_W-1:0] C_COS = '0,
    parameter logic signed [COEF_W-1:0] C_SIN = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_i,
    input  logic signed [IN_W-1:0] in_q,
    output logic                   rot_valid,
    output logic signed [IN_W-1:0] rot_i,
    output logic signed [IN_W-1:0] rot_q
);
    localparam int FRAC = COEF_W - 2;
    localparam int SW   = IN_W + COEF_W + 1;
    localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC - 1);
    localparam logic signed [SW-1:0] MAXV = SW'((1 << (IN_W - 1)) - 1);
    localparam logic signed [SW-1:0] MINV = -(SW'(1) <<< (IN_W - 1));

    logic signed [SW-1:0] ext_i, ext_q, sum_i, sum_q, rnd_i, rnd_q;

    // Clamp a wide value into the input range.
    function automatic logic signed [IN_W-1:0] clamp(input logic signed [SW-1:0] v);
        if (v > MAXV) return MAXV[IN_W-1:0];
        if (v < MINV) return MINV[IN_W-1:0];
        return v[IN_W-1:0];
    endfunction

    // Complex multiply by the conjugate rotation, then round to the input scale.
    always_comb begin
        ext_i = SW'(in_i);
        ext_q = SW'(in_q);
        sum_i = ext_i * SW'(C_COS) + ext_q * SW'(C_SIN);
        sum_q = ext_q * SW'(C_COS) - ext_i * SW'(C_SIN);
        rnd_i = (sum_i + HALF) >>> FRAC;
        rnd_q = (sum_q + HALF) >>> FRAC;
    end

    // Register the saturated products and delay the strobe to match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_valid <= 1'b0;
            rot_i     <= '0;
            rot_q     <= '0;
        end else begin
            rot_valid <= in_valid;
            if (in_valid) begin
                rot_i <= clamp(rnd_i);
                rot_q <= clamp(rnd_q);
            end
        end
    end

    // R9: saturation keeps the sign of the rounded products.
    assert_sat_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (rot_i[IN_W-1] == $past(rnd_i[SW-1])) && (rot_q[IN_W-1] == $past(rnd_q[SW-1])));

endmodule

// File: rtl/qdm_slicer.sv
// Quadrant slicer.
// Takes the sign bits of I and Q, subtracts the offset quadrant ROT and
// applies binary or Gray ordering. The symbol is registered with its strobe.
// Assumes the signs come from a sample that already sits in the quadrant centres.
module qdm_slicer #(
    parameter logic [1:0] ROT  = 2'd0,
    parameter bit         GRAY = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       neg_i,
    input  logic       neg_q,
    output logic       sym_valid,
    output logic [1:0] sym
);
    logic [1:0] idx;

    // Index of the symbol after removing the offset quadrant.
    always_comb idx = qdm_pkg::quadrant(neg_i, neg_q) - ROT;

    // Register the ordered symbol and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_valid <= 1'b0;
            sym       <= 2'd0;
        end else begin
            sym_valid <= in_valid;
            if (in_valid) sym <= qdm_pkg::order_sym(idx, GRAY);
        end
    end

    // R2: in Gray order, neighbouring quadrants differ in exactly one bit.
    assert_gray_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (GRAY && in_valid && $past(in_valid) && (qdm_pkg::quadrant(neg_i, neg_q) - qdm_pkg::quadrant($past(neg_i), $past(neg_q)) == 2'd1))
        |=> $countones(sym ^ $past(sym)) == 1);

endmodule

// File: rtl/qdm_serializer.sv
// Bit serializer.
// Sends each symbol as two bits, the first bit in the cycle the symbol
// arrives and the second in the next cycle. It stalls the input for the
// cycle after each accepted sample, so symbols never collide.
// Assumes symbols arrive at least two cycles apart, which the stall ensures.
module qdm_serializer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accepted,
    input  logic       sym_valid,
    input  logic [1:0] sym,
    output logic       stall,
    output logic       out_valid,
    output logic       out_bit
);
    logic second;
    logic lsb_hold;

    // Track the stall cycle and the pending second bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall    <= 1'b0;
            second   <= 1'b0;
            lsb_hold <= 1'b0;
        end else begin
            stall  <= accepted;
            second <= sym_valid;
            if (sym_valid) lsb_hold <= sym[0];
        end
    end

    // Select the first bit or the held second bit.
    always_comb begin
        out_valid = sym_valid | second;
        out_bit   = second ? lsb_hold : sym[1];
    end

    // R4: a first bit is always followed by its second bit in the next cycle.
    assert_pair_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> out_valid && (out_bit == $past(sym[0])));

    // R5: a symbol never arrives while the second bit of the previous one is going out.
    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> !sym_valid);

endmodule

// File: rtl/qpsk_hard_demapper.sv
// Hard-decision QPSK symbol demapper, top level.
// Classifies the phase at elaboration. For an odd multiple of pi/4, the
// slicer reads the input signs directly, with 1 cycle of latency. Otherwise
// a derotator is placed first, giving 2 cycles of latency. The output is
// either the 2-bit symbol or a serial bit pair sent first bit first.
// Assumes 0 <= PHASE < PHASE_DIV, COEF_W >= 3 and IN_W >= 2.
module qpsk_hard_demapper #(
    parameter int IN_W      = 12,
    parameter int COEF_W    = IN_W,
    parameter int PHASE_DIV = 64,
    parameter int PHASE     = 3,
    parameter bit GRAY      = 1'b0,
    parameter bit BIT_OUT   = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic signed [IN_W-1:0]       in_i,
    input  logic signed [IN_W-1:0]       in_q,
    output logic                         out_valid,
    output logic [(BIT_OUT ? 1 : 2)-1:0] out_sym
);
    localparam bit         DIRECT = qdm_pkg::odd_eighth(PHASE, PHASE_DIV);
    localparam logic [1:0] ROT    = qdm_pkg::offset_quadrant(PHASE, PHASE_DIV);
    localparam real        ANG    = qdm_pkg::derot_angle(PHASE, PHASE_DIV);
    localparam real        UNITY  = real'(1 << (COEF_W - 2));
    localparam logic signed [COEF_W-1:0] C_COS = COEF_W'(qdm_pkg::round_near(qdm_pkg::series_cos(ANG) * UNITY));
    localparam logic signed [COEF_W-1:0] C_SIN = COEF_W'(qdm_pkg::round_near(qdm_pkg::series_sin(ANG) * UNITY));

    logic       accepted;
    logic       dec_valid;
    logic       dec_neg_i, dec_neg_q;
    logic       sym_valid;
    logic [1:0] sym;

    // A sample is taken when it is offered and the block can take it.
    always_comb accepted = in_valid & in_ready;

    if (DIRECT) begin : g_direct
        // Signs feed the slicer directly; no multiply.
        always_comb begin
            dec_valid = accepted;
            dec_neg_i = in_i[IN_W-1];
            dec_neg_q = in_q[IN_W-1];
        end

        // R6: one cycle from acceptance to the first result.
        assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
            accepted |=> out_valid);

        // R8: an all-zero sample decides as quadrant 0.
        assert_zero_nonneg_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (accepted && in_i == '0 && in_q == '0) |=> sym == qdm_pkg::order_sym(2'd0 - ROT, GRAY));
    end else begin : g_rotate
        logic                   rot_valid;
        logic signed [IN_W-1:0] rot_i, rot_q;

        qdm_derotator #(
            .IN_W(IN_W), .COEF_W(COEF_W), .C_COS(C_COS), .C_SIN(C_SIN)
        ) u_rot (
            .clk(clk), .rst_n(rst_n), .in_valid(accepted),
            .in_i(in_i), .in_q(in_q),
            .rot_valid(rot_valid), .rot_i(rot_i), .rot_q(rot_q)
        );

        // Signs of the rotated sample feed the slicer.
        always_comb begin
            dec_valid = rot_valid;
            dec_neg_i = rot_i[IN_W-1];
            dec_neg_q = rot_q[IN_W-1];
        end

        // R7: two cycles from acceptance to the first result.
        assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
            accepted |=> ##1 out_valid);
    end

    qdm_slicer #(.ROT(ROT), .GRAY(GRAY)) u_slice (
        .clk(clk), .rst_n(rst_n), .in_valid(dec_valid),
        .neg_i(dec_neg_i), .neg_q(dec_neg_q),
        .sym_valid(sym_valid), .sym(sym)
    );

    if (BIT_OUT) begin : g_bits
        logic stall;
        logic ser_valid, ser_bit;

        qdm_serializer u_ser (
            .clk(clk), .rst_n(rst_n), .accepted(accepted),
            .sym_valid(sym_valid), .sym(sym),
            .stall(stall), .out_valid(ser_valid), .out_bit(ser_bit)
        );

        // Drive the serial output and the stall-based ready.
        always_comb begin
            in_ready  = ~stall;
            out_valid = ser_valid;
            out_sym   = ser_bit;
        end

        // R5: ready drops in the cycle after each accepted sample.
        assert_ready_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
            accepted |=> !in_ready);
    end else begin : g_word
        // Drive the integer output; the block is always ready.
        always_comb begin
            in_ready  = 1'b1;
            out_valid = sym_valid;
            out_sym   = sym;
        end
    end

endmodule

// File: tb/tb_qpsk_hard_demapper.sv
`timescale 1ns/1ps
module tb_qpsk_hard_demapper;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [W-1:0] in_i = '0, in_q = '0;

    logic rdy_d, val_d, rdy_t, val_t, rdy_s, val_s;
    logic [1:0] sym_d, sym_t;
    logic [0:0] bit_s;

    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // Rotated path: theta = 3*2pi/64 (16.875 deg), binary order, integer output.
    qpsk_hard_demapper #(.IN_W(W), .PHASE_DIV(64), .PHASE(3), .GRAY(1'b0), .BIT_OUT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_d),
        .in_i(in_i), .in_q(in_q), .out_valid(val_d), .out_sym(sym_d));
    // Direct path: theta = 3pi/4 (135 deg), Gray order, integer output.
    qpsk_hard_demapper #(.IN_W(W), .PHASE_DIV(64), .PHASE(24), .GRAY(1'b1), .BIT_OUT(1'b0)) dut_t (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_t),
        .in_i(in_i), .in_q(in_q), .out_valid(val_t), .out_sym(sym_t));
    // Direct path: theta = pi/4 (45 deg), Gray order, bit output.
    qpsk_hard_demapper #(.IN_W(W), .PHASE_DIV(64), .PHASE(8), .GRAY(1'b1), .BIT_OUT(1'b1)) dut_s (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_s),
        .in_i(in_i), .in_q(in_q), .out_valid(val_s), .out_sym(bit_s));

    localparam int NV = 12;
    localparam int VEC_ANG [NV] = '{20, 40, 110, 130, 200, 220, 290, 310, 45, 135, 250, 170};
    localparam int VEC_AMP [NV] = '{900, 300, 1500, 700, 1000, 400, 1200, 600, 1800, 250, 950, 1100};

    function automatic int exp_idx(input real a, input real th);
        real r;
        r = a - th + 45.0 + 720.0;
        return $rtoi(r / 90.0) % 4;
    endfunction

    // Gray order as stated in R2.
    function automatic int gray_of(input int m);
        case (m)
            0: return 0;
            1: return 1;
            2: return 3;
            default: return 2;
        endcase
    endfunction

    function automatic int to_fix(input real x);
        int v;
        v = (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
        if (v > 2047) v = 2047;
        if (v < -2048) v = -2048;
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one sample for one cycle and check all three instances against
    // their expected indices md, mt, ms.
    task automatic run_vec(input int vi, input int vq, input int md, input int mt, input int ms, input bit chk_d);
        int gt, gs;
        gt = gray_of(mt);
        gs = gray_of(ms);
        @(negedge clk);
        in_i = W'(vi); in_q = W'(vq); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 direct valid after 1 cycle", int'(val_t), 1);
        check("R2 R8 direct gray symbol", int'(sym_t), gt);
        check("R4 first bit valid", int'(val_s), 1);
        check("R4 first bit is msb", int'(bit_s), gs / 2);
        check("R5 bit-mode ready low after accept", int'(rdy_s), 0);
        check("R5 integer-mode ready high", int'(rdy_d), 1);
        check("R7 rotated not valid after 1 cycle", int'(val_d), 0);
        @(negedge clk);
        if (chk_d) begin
            check("R7 rotated valid after 2 cycles", int'(val_d), 1);
            check("R1 R3 rotated binary symbol", int'(sym_d), md);
        end
        check("R4 second bit valid", int'(val_s), 1);
        check("R4 second bit is lsb", int'(bit_s), gs % 2);
        check("R5 bit-mode ready back high", int'(rdy_s), 1);
        check("R6 direct valid one cycle only", int'(val_t), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state.
        check("R10 out_valid low in reset", int'(val_d | val_t | val_s), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 out_valid low after reset", int'(val_d | val_t | val_s), 0);
        check("R10 bit-mode ready high after reset", int'(rdy_s), 1);

        // Table of angles walked by one loop: R1, R2, R6, R7.
        for (int k = 0; k < NV; k++) begin
            real a, rad;
            a = real'(VEC_ANG[k]);
            rad = a * 3.14159265358979 / 180.0;
            run_vec(to_fix(real'(VEC_AMP[k]) * $cos(rad)), to_fix(real'(VEC_AMP[k]) * $sin(rad)),
                    exp_idx(a, 16.875), exp_idx(a, 135.0), exp_idx(a, 45.0), 1'b1);
        end

        // R9: full-scale inputs saturate inside the rotation but keep the decision.
        run_vec(2047, 2047, exp_idx(45.0, 16.875), exp_idx(45.0, 135.0), exp_idx(45.0, 45.0), 1'b1);
        run_vec(-2048, -2048, exp_idx(225.0, 16.875), exp_idx(225.0, 135.0), exp_idx(225.0, 45.0), 1'b1);
        run_vec(2047, -2048, exp_idx(315.0, 16.875), exp_idx(315.0, 135.0), exp_idx(315.0, 45.0), 1'b1);

        // R8: zero components count as non-negative (offset quadrants 1 and 0).
        run_vec(0, 0, 0, 3, 0, 1'b0);
        run_vec(0, -100, 0, 2, 3, 1'b0);
        run_vec(-100, 0, 0, 0, 1, 1'b0);

        // R5 and R4: valid held while ready is low; the stalled sample must not be taken.
        @(negedge clk);
        in_i = W'(to_fix(800.0 * $cos(110.0 * 3.14159265358979 / 180.0)));
        in_q = W'(to_fix(800.0 * $sin(110.0 * 3.14159265358979 / 180.0)));
        in_valid = 1'b1;
        @(negedge clk);
        check("R4 stream bit 1 (sample A msb)", int'(bit_s), 0);
        check("R5 ready low during stall", int'(rdy_s), 0);
        in_i = W'(to_fix(800.0 * $cos(290.0 * 3.14159265358979 / 180.0)));
        in_q = W'(to_fix(800.0 * $sin(290.0 * 3.14159265358979 / 180.0)));
        @(negedge clk);
        check("R4 stream bit 2 (sample A lsb)", int'(bit_s), 1);
        check("R5 ready high after stall", int'(rdy_s), 1);
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 stream bit 3 (sample B msb)", int'(bit_s), 1);
        check("R4 stream valid on bit 3", int'(val_s), 1);
        @(negedge clk);
        check("R4 stream bit 4 (sample B lsb)", int'(bit_s), 0);
        @(negedge clk);
        check("R5 no extra output after stream", int'(val_s), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule